// File: doc/BRIEF.md
# Timing-Error Replay Controller

This block wraps one pipelined arithmetic datapath and recovers it from timing errors that in-situ detectors flag on the 32-bit single-precision result word. The datapath is modelled as a shift pipeline of `STAGES` registers. A small integer function stands in for the arithmetic, which lies outside this block. One operation is outstanding at a time. The caller presents operands, an opcode, an accuracy mode and a mask width, and waits for `done_o`.

When the operation reaches the last stage, the detector flags are filtered by the mode. In accurate mode every bit counts. In approximate mode the lowest N fraction bits are ignored, while the sign and exponent bits are always checked. A clean result is written to the result register and `done_o` pulses for one cycle. A result with an error that survives the filter is not written. Instead the pipeline is flushed and the captured operation is reissued `STAGES` times back to back, at the same clock rate. Only the last copy is allowed to commit; the earlier copies just refill the stage registers. No new operation is accepted until the sequence finishes.

Top module: `err_replay_unit`

## Requirements
- R1: After reset `res_o` is 0, `done_o` and `rec_busy_o` are low, and `in_ready_o` is high.
- R2: An operation accepted at a clock edge with no error evaluated at its tail commits exactly `STAGES` edges later. `done_o` is high for that one cycle only, and `res_o` then holds the result. Opcode encoding: 0 is a+b, 1 is a-b, 2 is a XOR b, 3 is a AND b (modulo 2^32).
- R3: When the tail result of a live operation carries an unmasked error flag, `res_o` keeps its previous value and `done_o` stays low.
- R4: After an unmasked error, the pipeline is flushed and the operation is reissued `STAGES` times. `rec_busy_o` is high from the cycle after the error until the commit. If the final copy is clean, the result commits 2·`STAGES` edges after the error edge, with the correct value.
- R5: Error flags present while the tail holds a filler copy or no operation have no effect.
- R6: In approximate mode (`in_approx`=1), flags on bits [N-1:0] of the result are ignored, and the operation commits on its first pass.
- R7: Flags on the sign (bit 31) or exponent (bits 30:23) always start recovery. In approximate mode, flags on fraction bits N through 22 also start recovery.
- R8: Approximate mode with N=0 behaves like accurate mode. N values above 23 act as 23.
- R9: `in_ready_o` is low from the accepting edge until the commit. An `in_valid` presented while it is low is ignored and does not disturb the pending result.
- R10: An unmasked error on the final replayed copy starts a fresh recovery sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request |
| in_ready_o | output | 1 | Issue accepted when high with in_valid |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_op | input | 2 | Opcode |
| in_approx | input | 1 | 1 selects approximate mode |
| in_nbits | input | 5 | Count of low fraction bits to ignore in approximate mode |
| err_flags | input | 32 | Per-bit timing-error flags for the tail result |
| res_o | output | 32 | Last committed result |
| done_o | output | 1 | One-cycle commit pulse |
| rec_busy_o | output | 1 | Recovery sequence in progress |

## Verification
The bench places error flags on the cycle when the live operation sits at the tail. It also places them on the filler-copy cycles and the idle cycles, so a design that commits or reacts to a filler copy gives a wrong `done_o` time. It probes the mask edges: bit N-1 against bit N, N=0, N above 23, and the sign and exponent bits under a full mask. A design with an off-by-one mask or without the clamp would commit when it should replay, or replay when it should commit. A double error on the replayed copy, together with junk issues held high during the whole sequence, would reveal a design that ends recovery early or accepts work while busy.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
  localparam int WORD_W = 32;
  localparam int FRAC_W = 23;
  localparam int NSEL_W = 5;
  localparam int OPC_W  = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 2'd0,
    OPC_SUB = 2'd1,
    OPC_XOR = 2'd2,
    OPC_AND = 2'd3
  } rpl_opc_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RUN    = 2'd1,
    SQ_REPLAY = 2'd2,
    SQ_DRAIN  = 2'd3
  } rpl_state_e;

  // Stand-in arithmetic for the datapath.
  function automatic logic [WORD_W-1:0] rpl_calc(
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b,
    input logic [OPC_W-1:0]  op
  );
    case (rpl_opc_e'(op))
      OPC_ADD: return a + b;
      OPC_SUB: return a - b;
      OPC_XOR: return a ^ b;
      default: return a & b;
    endcase
  endfunction

  // Bits whose error flags are ignored; only fraction bits can be masked.
  function automatic logic [WORD_W-1:0] rpl_ignore_mask(
    input logic              approx,
    input logic [NSEL_W-1:0] nbits
  );
    logic [NSEL_W-1:0] nc;
    nc = (nbits > NSEL_W'(FRAC_W)) ? NSEL_W'(FRAC_W) : nbits;
    if (!approx) return '0;
    return (WORD_W'(1) << nc) - WORD_W'(1);
  endfunction
endpackage

// File: rtl/rpl_errmask.sv
module rpl_errmask
  import rpl_pkg::*;
(
  input  logic              tail_live,
  input  logic              approx,
  input  logic [NSEL_W-1:0] nbits,
  input  logic [WORD_W-1:0] flags,
  output logic              err_hit
);
  logic [WORD_W-1:0] kept;

  always_comb begin
    kept    = flags & ~rpl_ignore_mask(approx, nbits);
    err_hit = tail_live && (|kept);
  end
endmodule

// File: rtl/rpl_pipe.sv
module rpl_pipe
  import rpl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              push_live,
  input  logic [WORD_W-1:0] push_res,
  output logic              tail_live,
  output logic [WORD_W-1:0] tail_res
);
  logic              live_q [STAGES];
  logic [WORD_W-1:0] res_q  [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      live_q[0] <= 1'b0;
    end else begin
      live_q[0] <= push && push_live;
    end
    if (push) res_q[0] <= push_res;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n || flush) live_q[s] <= 1'b0;
      else                 live_q[s] <= live_q[s-1];
      res_q[s] <= res_q[s-1];
    end
  end

  assign tail_live = live_q[STAGES-1];
  assign tail_res  = res_q[STAGES-1];
endmodule

// File: rtl/rpl_seq.sv
module rpl_seq
  import rpl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic tail_live,
  input  logic err_hit,
  output logic in_ready,
  output logic rec_busy,
  output logic accept,
  output logic push,
  output logic push_live,
  output logic flush,
  output logic commit
);
  localparam int CNT_W = $clog2(STAGES + 1);

  rpl_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_copy;

  always_comb begin
    in_ready  = (st_q == SQ_IDLE);
    rec_busy  = (st_q == SQ_REPLAY) || (st_q == SQ_DRAIN);
    accept    = in_valid && in_ready;
    last_copy = (cnt_q == CNT_W'(STAGES - 1));
    push      = accept || (st_q == SQ_REPLAY);
    push_live = accept || last_copy;
    commit    = tail_live && !err_hit;
    flush     = err_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE:   if (accept) st_q <= SQ_RUN;
        SQ_REPLAY: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_copy) st_q <= SQ_DRAIN;
        end
        default: begin
          if (commit) st_q <= SQ_IDLE;
          else if (err_hit) begin
            st_q  <= SQ_REPLAY;
            cnt_q <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/err_replay_unit.sv
module err_replay_unit
  import rpl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [OPC_W-1:0]  in_op,
  input  logic              in_approx,
  input  logic [NSEL_W-1:0] in_nbits,
  input  logic [WORD_W-1:0] err_flags,
  output logic [WORD_W-1:0] res_o,
  output logic              done_o,
  output logic              rec_busy_o
);
  // Capture register for the outstanding operation
  logic [WORD_W-1:0] cap_a, cap_b;
  logic [OPC_W-1:0]  cap_op;
  logic              cap_approx;
  logic [NSEL_W-1:0] cap_nbits;

  logic              accept, push, push_live, flush, commit;
  logic              tail_live, err_hit;
  logic [WORD_W-1:0] tail_res, push_res;
  logic [WORD_W-1:0] res_q;
  logic              done_q;

  assign push_res = accept ? rpl_calc(in_a, in_b, in_op)
                           : rpl_calc(cap_a, cap_b, cap_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_a      <= '0;
      cap_b      <= '0;
      cap_op     <= '0;
      cap_approx <= 1'b0;
      cap_nbits  <= '0;
      res_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      if (accept) begin
        cap_a      <= in_a;
        cap_b      <= in_b;
        cap_op     <= in_op;
        cap_approx <= in_approx;
        cap_nbits  <= in_nbits;
      end
      if (commit) res_q <= tail_res;
      done_q <= commit;
    end
  end

  rpl_seq #(.STAGES(STAGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tail_live(tail_live),
    .err_hit(err_hit), .in_ready(in_ready_o), .rec_busy(rec_busy_o),
    .accept(accept), .push(push), .push_live(push_live), .flush(flush),
    .commit(commit)
  );

  rpl_pipe #(.STAGES(STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push),
    .push_live(push_live), .push_res(push_res),
    .tail_live(tail_live), .tail_res(tail_res)
  );

  rpl_errmask u_mask (
    .tail_live(tail_live), .approx(cap_approx), .nbits(cap_nbits),
    .flags(err_flags), .err_hit(err_hit)
  );

  assign res_o  = res_q;
  assign done_o = done_q;
endmodule

// File: rtl/rpl_checker.sv
module rpl_checker #(
  parameter int STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tail_live,
  input logic        err_hit,
  input logic        cap_approx,
  input logic [31:0] err_flags,
  input logic [31:0] res_o,
  input logic        done_o,
  input logic        rec_busy_o,
  input logic        in_ready_o
);
  logic [15:0] rec_cnt;
  logic        in_rec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_cnt <= '0;
      in_rec  <= 1'b0;
    end else if (err_hit) begin
      rec_cnt <= '0;
      in_rec  <= 1'b1;
    end else begin
      if (rec_busy_o) rec_cnt <= rec_cnt + 16'd1;
      if (done_o)     in_rec  <= 1'b0;
    end
  end

  assert_hold_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> $stable(res_o));
  assert_no_done_on_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> !done_o);
  assert_busy_after_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> rec_busy_o);
  assert_replay_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && in_rec) |-> (rec_cnt == 16'(2 * STAGES)));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_protected_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_live && (|err_flags[31:23])) |-> err_hit);
  assert_accurate_all_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_live && !cap_approx && (|err_flags)) |-> err_hit);
  assert_refuse_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_busy_o |-> !in_ready_o);
endmodule

bind err_replay_unit rpl_checker #(.STAGES(STAGES)) u_check (
  .clk(clk), .rst_n(rst_n), .tail_live(tail_live), .err_hit(err_hit),
  .cap_approx(cap_approx), .err_flags(err_flags), .res_o(res_o),
  .done_o(done_o), .rec_busy_o(rec_busy_o), .in_ready_o(in_ready_o)
);

// File: tb/err_replay_unit_test.sv
module err_replay_unit_test;
  localparam int M = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_a = '0, in_b = '0;
  logic [1:0]  in_op = '0;
  logic        in_approx = 1'b0;
  logic [4:0]  in_nbits = '0;
  logic [31:0] err_flags = '0;
  logic [31:0] res_o;
  logic        done_o, rec_busy_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_res = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  err_replay_unit #(.STAGES(M)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready_o(in_ready_o),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_approx(in_approx),
    .in_nbits(in_nbits), .err_flags(err_flags), .res_o(res_o),
    .done_o(done_o), .rec_busy_o(rec_busy_o)
  );

  function automatic logic [31:0] model_res(logic [31:0] a, logic [31:0] b, logic [1:0] op);
    if (op == 2'd0) return a + b;
    if (op == 2'd1) return a + (~b) + 32'd1;
    if (op == 2'd2) return a ^ b;
    return a & b;
  endfunction

  function automatic bit model_err(logic [31:0] f, logic approx, int n);
    int lim = (n < 23) ? n : 23;
    for (int i = 0; i < 32; i++)
      if (f[i] && !(approx && i < lim)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run_case(string req, logic [31:0] a, logic [31:0] b, logic [1:0] op,
                          logic approx, int n, logic [31:0] f1, logic [31:0] ffill,
                          logic [31:0] f2, logic [31:0] f3);
    logic [31:0] expv = model_res(a, b, op);
    bit e1 = model_err(f1, approx, n);
    bit e2 = model_err(f2, approx, n);
    int dedge = !e1 ? M : (!e2 ? 3*M : 5*M);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_op = op;
    in_approx = approx; in_nbits = 5'(n); err_flags = ffill;
    for (int k = 1; k <= dedge + 1; k++) begin
      @(negedge clk);
      chk(req, "done_o", 32'(done_o), 32'(k - 1 == dedge));
      chk(req, "res_o", res_o, (k - 1 >= dedge) ? expv : last_res);
      chk(req, "rec_busy_o", 32'(rec_busy_o), 32'(e1 && k - 1 >= M && k - 1 < dedge));
      chk("R9", "in_ready_o", 32'(in_ready_o), 32'(k - 1 >= dedge));
      in_valid = (k <= dedge);
      in_a = ~a; in_b = b ^ 32'h5a5a_0f0f; in_op = op + 2'd1;
      in_approx = ~approx; in_nbits = 5'd31;
      if (k == M) err_flags = f1;
      else if (k == 3*M) err_flags = f2;
      else if (k == 5*M) err_flags = f3;
      else err_flags = ffill;
    end
    in_valid = 1'b0; err_flags = '0;
    last_res = expv;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "res_o", res_o, 32'h0);
    chk("R1", "done_o", 32'(done_o), 32'h0);
    chk("R1", "rec_busy_o", 32'(rec_busy_o), 32'h0);
    chk("R1", "in_ready_o", 32'(in_ready_o), 32'h1);
    rst_n = 1'b1;
    // R2 clean operations, every opcode
    run_case("R2", 32'h0000_0010, 32'h0000_0022, 2'd0, 1'b0, 0, '0, '0, '0, '0);
    run_case("R2", 32'h0000_0001, 32'h0000_0003, 2'd1, 1'b0, 0, '0, '0, '0, '0);
    run_case("R2", 32'hdead_beef, 32'h1234_5678, 2'd2, 1'b0, 0, '0, '0, '0, '0);
    run_case("R2", 32'hf0f0_ff00, 32'h3c3c_0ff0, 2'd3, 1'b0, 0, '0, '0, '0, '0);
    // R3 R4 R5 accurate error on bit 0, noisy flags on filler cycles
    run_case("R3_R4_R5", 32'h4040_0000, 32'h0000_1111, 2'd0, 1'b0, 0,
             32'h1, 32'hffff_ffff, '0, '0);
    // R6 approximate N=8, bit 7 ignored
    run_case("R6", 32'h0000_0aaa, 32'h0000_0555, 2'd2, 1'b1, 8, 32'h80, '0, '0, '0);
    // R7 approximate N=8, bit 8 recovers
    run_case("R7", 32'h0100_0000, 32'h0000_00ff, 2'd1, 1'b1, 8, 32'h100, '0, '0, '0);
    // R7 sign and exponent protected under full mask
    run_case("R7", 32'h0000_7777, 32'h0000_1000, 2'd0, 1'b1, 23, 32'h8000_0000, '0, '0, '0);
    run_case("R7", 32'h0000_7777, 32'h0000_2000, 2'd3, 1'b1, 23, 32'h0200_0000, '0, '0, '0);
    // R8 N=0 in approximate mode, and clamp above 23
    run_case("R8", 32'h0000_0009, 32'h0000_0009, 2'd0, 1'b1, 0, 32'h1, '0, '0, '0);
    run_case("R8", 32'h0000_0abc, 32'h0000_0123, 2'd0, 1'b1, 31, 32'h0040_0000, '0, '0, '0);
    run_case("R8", 32'h0000_0abc, 32'h0000_0321, 2'd2, 1'b1, 31, 32'h0080_0000, '0, '0, '0);
    // R10 second error on the replayed copy
    run_case("R10", 32'hcafe_0000, 32'h0000_babe, 2'd2, 1'b0, 0,
             32'h4, 32'h0000_ff00, 32'h0010_0000, '0);
    repeat (2) @(negedge clk);
    chk("R9", "res_o after junk issues", res_o, last_res);
    chk("R2", "done_o idle", 32'(done_o), 32'h0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule